// File: doc/BRIEF.md
# Partition-Pairing Memory Request Scheduler

This block schedules reads and writes for one bank of a phase-change memory, where several partitions share the bank's write drivers and sense amplifiers. Requests arrive one at a time. Each carries a direction, a partition number and an identifier, and waits in a small age-ordered queue. Whenever the bank is idle, the scheduler issues one command. That command is either a plain read or write, or a combined command that serves two requests in different partitions of the bank together: a read with a write, or a read with a read.

A combined command is issued only when two conditions hold. First, the sum of the programmable power costs of its two members must fit a programmable budget. Second, the pairing must not skip a request that has already been passed over as many times as a programmable backlog limit allows. The bank's occupancy after each command is modelled by a down-counter, loaded with a duration that depends on the kind of command.

Top module: `part_pair_sched`

## Requirements
- R1: The queue holds 8 requests. `reqReady` is low exactly when 8 requests are pending. A request is taken at a clock edge only when `reqValid` and `reqReady` are both high, and a request offered while `reqReady` is low is dropped.
- R2: A command is decided at an edge where `bankBusy` is low and the queue is not empty. `cmdValid` is high for exactly the one cycle after that edge. The oldest pending request is always a member of the command, and its partition and identifier appear on `cmdPartA` and `cmdIdA`.
- R3: A combined read-with-read command has `cmdType` 3. It serves two reads in different partitions.
- R4: A combined read-with-write command has `cmdType` 2. It serves one read and one write in different partitions. Two writes are never combined.
- R5: Two requests to the same partition are never combined. A younger request is never chosen as a partner while an older pending request to its partition is passed over, so requests to one partition leave in arrival order.
- R6: The partner is the oldest pending request that satisfies R3 to R5 and R7. Its partition and identifier appear on `cmdPartB` and `cmdIdB`.
- R7: A pair is allowed only when the cost of the oldest request plus the cost of the candidate does not exceed `cfgBudget`. A read costs `cfgCostRd` and a write costs `cfgCostWr`. A candidate that fails this test is skipped and the search continues with younger entries.
- R8: Each request counts how many times a combined command took a partner younger than it while passing it over. If any request older than the chosen partner (other than the oldest) has a count of at least `cfgBacklogLimit`, the oldest request is issued alone.
- R9: The bank stays occupied for 19 cycles after a read, 47 after a write, 48 after a read-with-write and 30 after a read-with-read. `bankBusy` is high from the `cmdValid` cycle for that many cycles minus one, so successive commands are exactly that many cycles apart.
- R10: A single read has `cmdType` 0 and a single write has `cmdType` 1. For a single command, `cmdPartB` and `cmdIdB` are zero.
- R11: After reset the queue is empty, `reqReady` is high, and `cmdValid`, `cmdType` and `bankBusy` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | New request offered |
| reqIsWrite | input | 1 | 1 = write, 0 = read |
| reqPart | input | 2 | Target partition |
| reqId | input | 4 | Request identifier |
| reqReady | output | 1 | Queue has a free slot |
| cfgCostRd | input | 8 | Power cost of one read |
| cfgCostWr | input | 8 | Power cost of one write |
| cfgBudget | input | 9 | Power budget for a combined command |
| cfgBacklogLimit | input | 4 | Pass-over count that forbids further skipping |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdType | output | 2 | 0 read, 1 write, 2 read-with-write, 3 read-with-read |
| cmdPartA | output | 2 | Partition of the oldest request served |
| cmdIdA | output | 4 | Identifier of the oldest request served |
| cmdPartB | output | 2 | Partition of the partner, zero if single |
| cmdIdB | output | 4 | Identifier of the partner, zero if single |
| bankBusy | output | 1 | Bank occupied by the last command |

## Verification
At a single edge the queue can both lose one or two entries to an issued command and gain a new arrival. That edge must compact the survivors, bump their pass-over counts and append the newcomer without misplacing anything. The bench provokes this by offering requests in the very cycle the bank becomes idle, both in directed sequences and in a long random run. It judges the result against a behavioural queue model compared on every clock, so any misplaced entry appears later as a wrong command type, partner or identifier.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_WR  = 2'd1,
    CMD_RWW = 2'd2,
    CMD_RWR = 2'd3
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;
    logic pair;
    cmd_e kind;
  } strobe_t;
endpackage

// File: rtl/pps_ctrl.sv
`timescale 1ns/1ps
module pps_ctrl import pps_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter int PART_W  = 2,
  parameter int CNT_W   = 4,
  parameter int POW_W   = 8,
  parameter int LAT_RD  = 19,
  parameter int LAT_WR  = 47,
  parameter int LAT_RWW = 48,
  parameter int LAT_RWR = 30
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [DEPTH-1:0]                  qValid,
  input  logic [DEPTH-1:0]                  qWrite,
  input  logic [DEPTH-1:0][PART_W-1:0]      qPart,
  input  logic [DEPTH-1:0][CNT_W-1:0]       qCnt,
  input  logic [POW_W-1:0]                  cfgCostRd,
  input  logic [POW_W-1:0]                  cfgCostWr,
  input  logic [POW_W:0]                    cfgBudget,
  input  logic [CNT_W-1:0]                  cfgBacklogLimit,
  output strobe_t                           ctl,
  output logic [$clog2(DEPTH)-1:0]          partnerIdx,
  output logic                              bankBusy
);
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int NPART   = 1 << PART_W;
  localparam int MAX_A   = (LAT_RD > LAT_WR) ? LAT_RD : LAT_WR;
  localparam int MAX_B   = (LAT_RWW > LAT_RWR) ? LAT_RWW : LAT_RWR;
  localparam int MAX_LAT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int BUSY_W  = $clog2(MAX_LAT + 1);

  logic [BUSY_W-1:0] busyCnt, lat;
  logic [NPART-1:0]  partSeen;
  logic              starveSeen, found, blocked;
  logic [IDX_W-1:0]  pIdx;
  logic [POW_W:0]    headCost, candCost;

  // oldest-compatible partner search
  always_comb begin
    partSeen   = '0;
    starveSeen = 1'b0;
    found      = 1'b0;
    blocked    = 1'b0;
    pIdx       = '0;
    candCost   = '0;
    headCost   = qWrite[0] ? {1'b0, cfgCostWr} : {1'b0, cfgCostRd};
    for (int j = 1; j < DEPTH; j++) begin
      candCost = qWrite[j] ? {1'b0, cfgCostWr} : {1'b0, cfgCostRd};
      if (qValid[j] && !found) begin
        if ((qPart[j] != qPart[0]) && !(qWrite[0] && qWrite[j]) &&
            !partSeen[qPart[j]] && ((headCost + candCost) <= cfgBudget)) begin
          found   = 1'b1;
          pIdx    = IDX_W'(j);
          blocked = starveSeen;
        end else begin
          partSeen[qPart[j]] = 1'b1;
          if (qCnt[j] >= cfgBacklogLimit) starveSeen = 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.issue = (busyCnt == '0) && qValid[0];
    ctl.pair  = found && !blocked;
    if (ctl.pair)
      ctl.kind = (qWrite[0] || qWrite[pIdx]) ? CMD_RWW : CMD_RWR;
    else
      ctl.kind = qWrite[0] ? CMD_WR : CMD_RD;
    unique case (ctl.kind)
      CMD_RD:  lat = BUSY_W'(LAT_RD - 1);
      CMD_WR:  lat = BUSY_W'(LAT_WR - 1);
      CMD_RWW: lat = BUSY_W'(LAT_RWW - 1);
      default: lat = BUSY_W'(LAT_RWR - 1);
    endcase
  end

  assign partnerIdx = pIdx;
  assign bankBusy   = (busyCnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             busyCnt <= '0;
    else if (ctl.issue)     busyCnt <= lat;
    else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
  end
endmodule

// File: rtl/pps_datapath.sv
`timescale 1ns/1ps
module pps_datapath import pps_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int PART_W = 2,
  parameter int ID_W   = 4,
  parameter int CNT_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reqValid,
  input  logic                          reqIsWrite,
  input  logic [PART_W-1:0]             reqPart,
  input  logic [ID_W-1:0]               reqId,
  output logic                          reqReady,
  input  strobe_t                       ctl,
  input  logic [$clog2(DEPTH)-1:0]      partnerIdx,
  output logic [DEPTH-1:0]              qValid,
  output logic [DEPTH-1:0]              qWrite,
  output logic [DEPTH-1:0][PART_W-1:0]  qPart,
  output logic [DEPTH-1:0][CNT_W-1:0]   qCnt,
  output logic                          cmdValid,
  output logic [1:0]                    cmdType,
  output logic [PART_W-1:0]             cmdPartA,
  output logic [ID_W-1:0]               cmdIdA,
  output logic [PART_W-1:0]             cmdPartB,
  output logic [ID_W-1:0]               cmdIdB
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]             vR, wR, nV, nW;
  logic [DEPTH-1:0][PART_W-1:0] pR, nP;
  logic [DEPTH-1:0][ID_W-1:0]   iR, nI;
  logic [DEPTH-1:0][CNT_W-1:0]  cR, nC;
  logic [IDX_W:0]               k;
  logic                         gone, bump;

  assign reqReady = !vR[DEPTH-1];
  assign qValid   = vR;
  assign qWrite   = wR;
  assign qPart    = pR;
  assign qCnt     = cR;

  // remove served entries, age the skipped ones, compact, append
  always_comb begin
    nV = '0; nW = '0; nP = '0; nI = '0; nC = '0;
    k  = '0;
    gone = 1'b0;
    bump = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      gone = ctl.issue && ((i == 0) || (ctl.pair && (IDX_W'(i) == partnerIdx)));
      bump = ctl.issue && ctl.pair && (i != 0) && (IDX_W'(i) < partnerIdx) && (cR[i] != '1);
      if (vR[i] && !gone) begin
        nV[k[IDX_W-1:0]] = 1'b1;
        nW[k[IDX_W-1:0]] = wR[i];
        nP[k[IDX_W-1:0]] = pR[i];
        nI[k[IDX_W-1:0]] = iR[i];
        nC[k[IDX_W-1:0]] = cR[i] + CNT_W'(bump);
        k = k + 1'b1;
      end
    end
    if (reqValid && reqReady && (k < (IDX_W+1)'(DEPTH))) begin
      nV[k[IDX_W-1:0]] = 1'b1;
      nW[k[IDX_W-1:0]] = reqIsWrite;
      nP[k[IDX_W-1:0]] = reqPart;
      nI[k[IDX_W-1:0]] = reqId;
      nC[k[IDX_W-1:0]] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vR <= '0; wR <= '0; pR <= '0; iR <= '0; cR <= '0;
    end else begin
      vR <= nV; wR <= nW; pR <= nP; iR <= nI; cR <= nC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdValid <= 1'b0;
      cmdType  <= '0;
      cmdPartA <= '0;
      cmdIdA   <= '0;
      cmdPartB <= '0;
      cmdIdB   <= '0;
    end else begin
      cmdValid <= ctl.issue;
      if (ctl.issue) begin
        cmdType  <= ctl.kind;
        cmdPartA <= pR[0];
        cmdIdA   <= iR[0];
        cmdPartB <= ctl.pair ? pR[partnerIdx] : '0;
        cmdIdB   <= ctl.pair ? iR[partnerIdx] : '0;
      end
    end
  end
endmodule

// File: rtl/part_pair_sched.sv
`timescale 1ns/1ps
module part_pair_sched import pps_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter int PART_W  = 2,
  parameter int ID_W    = 4,
  parameter int CNT_W   = 4,
  parameter int POW_W   = 8,
  parameter int LAT_RD  = 19,
  parameter int LAT_WR  = 47,
  parameter int LAT_RWW = 48,
  parameter int LAT_RWR = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqIsWrite,
  input  logic [PART_W-1:0] reqPart,
  input  logic [ID_W-1:0]   reqId,
  output logic              reqReady,
  input  logic [POW_W-1:0]  cfgCostRd,
  input  logic [POW_W-1:0]  cfgCostWr,
  input  logic [POW_W:0]    cfgBudget,
  input  logic [CNT_W-1:0]  cfgBacklogLimit,
  output logic              cmdValid,
  output logic [1:0]        cmdType,
  output logic [PART_W-1:0] cmdPartA,
  output logic [ID_W-1:0]   cmdIdA,
  output logic [PART_W-1:0] cmdPartB,
  output logic [ID_W-1:0]   cmdIdB,
  output logic              bankBusy
);
  localparam int IDX_W = $clog2(DEPTH);

  strobe_t                      ctl;
  logic [IDX_W-1:0]             partnerIdx;
  logic [DEPTH-1:0]             qValid, qWrite;
  logic [DEPTH-1:0][PART_W-1:0] qPart;
  logic [DEPTH-1:0][CNT_W-1:0]  qCnt;

  pps_ctrl #(
    .DEPTH(DEPTH), .PART_W(PART_W), .CNT_W(CNT_W), .POW_W(POW_W),
    .LAT_RD(LAT_RD), .LAT_WR(LAT_WR), .LAT_RWW(LAT_RWW), .LAT_RWR(LAT_RWR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .qValid(qValid), .qWrite(qWrite), .qPart(qPart), .qCnt(qCnt),
    .cfgCostRd(cfgCostRd), .cfgCostWr(cfgCostWr), .cfgBudget(cfgBudget),
    .cfgBacklogLimit(cfgBacklogLimit),
    .ctl(ctl), .partnerIdx(partnerIdx), .bankBusy(bankBusy)
  );

  pps_datapath #(
    .DEPTH(DEPTH), .PART_W(PART_W), .ID_W(ID_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqIsWrite(reqIsWrite), .reqPart(reqPart), .reqId(reqId),
    .reqReady(reqReady),
    .ctl(ctl), .partnerIdx(partnerIdx),
    .qValid(qValid), .qWrite(qWrite), .qPart(qPart), .qCnt(qCnt),
    .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdPartA(cmdPartA), .cmdIdA(cmdIdA), .cmdPartB(cmdPartB), .cmdIdB(cmdIdB)
  );
endmodule

// File: rtl/pps_checker.sv
`timescale 1ns/1ps
module pps_checker #(
  parameter int PART_W = 2,
  parameter int POW_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmdValid,
  input logic [1:0]        cmdType,
  input logic [PART_W-1:0] cmdPartA,
  input logic [PART_W-1:0] cmdPartB,
  input logic              bankBusy,
  input logic [POW_W-1:0]  cfgCostRd,
  input logic [POW_W-1:0]  cfgCostWr,
  input logic [POW_W:0]    cfgBudget
);
  AST_PAIR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdType[1]) |-> (cmdPartA != cmdPartB)); // R5
  AST_IDLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |-> $past(!bankBusy)); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |=> !cmdValid); // R2
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |-> bankBusy); // R9
  AST_RWR_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdType == 2'd3) |->
      (({1'b0, $past(cfgCostRd)} + {1'b0, $past(cfgCostRd)}) <= $past(cfgBudget))); // R7
  AST_RWW_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdType == 2'd2) |->
      (({1'b0, $past(cfgCostRd)} + {1'b0, $past(cfgCostWr)}) <= $past(cfgBudget))); // R7
endmodule

bind part_pair_sched pps_checker #(.PART_W(PART_W), .POW_W(POW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdType(cmdType),
  .cmdPartA(cmdPartA), .cmdPartB(cmdPartB), .bankBusy(bankBusy),
  .cfgCostRd(cfgCostRd), .cfgCostWr(cfgCostWr), .cfgBudget(cfgBudget)
);

// File: tb/part_pair_sched_tb.sv
`timescale 1ns/1ps
module part_pair_sched_tb;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqIsWrite = 1'b0;
  logic [1:0] reqPart = '0;
  logic [3:0] reqId = '0;
  logic [7:0] cfgCostRd = 8'd2, cfgCostWr = 8'd5;
  logic [8:0] cfgBudget = 9'd10;
  logic [3:0] cfgBacklogLimit = 4'd3;
  logic reqReady, cmdValid, bankBusy;
  logic [1:0] cmdType, cmdPartA, cmdPartB;
  logic [3:0] cmdIdA, cmdIdB;

  part_pair_sched u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIsWrite(reqIsWrite),
    .reqPart(reqPart), .reqId(reqId), .reqReady(reqReady),
    .cfgCostRd(cfgCostRd), .cfgCostWr(cfgCostWr), .cfgBudget(cfgBudget),
    .cfgBacklogLimit(cfgBacklogLimit), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdPartA(cmdPartA), .cmdIdA(cmdIdA), .cmdPartB(cmdPartB), .cmdIdB(cmdIdB),
    .bankBusy(bankBusy)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int cRd = 2, cWr = 5, cBud = 10, cLim = 3;
  int cyc = 0, nextId = 0;

  // reference model state
  int mW[$], mP[$], mI[$], mC[$];
  int mBusy = 0;
  bit eValid = 0, eReady = 1;
  int eType = 0, ePA = 0, ePB = 0, eIA = 0, eIB = 0;

  // log of observed commands
  int logT[$], logPA[$], logPB[$], logIA[$], logCyc[$];
  int served = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, int p);
    bit readyPre, issue, pair, starve;
    bit seen[4];
    int j, lat, cost;
    @(negedge clk);
    cyc++;
    chk(reqReady === eReady, "R1 reqReady", int'(reqReady), int'(eReady));
    chk(bankBusy === (mBusy != 0), "R9 bankBusy", int'(bankBusy), int'(mBusy != 0));
    chk(cmdValid === eValid, "R2 cmdValid", int'(cmdValid), int'(eValid));
    if (cmdValid && eValid) begin
      chk(cmdType == 2'(eType), "R3 R4 R5 R7 R8 R10 cmdType", int'(cmdType), eType);
      chk(cmdPartA == 2'(ePA) && cmdIdA == 4'(eIA), "R2 cmdA", int'(cmdIdA), eIA);
      chk(cmdPartB == 2'(ePB) && cmdIdB == 4'(eIB), "R6 R10 cmdB", int'(cmdIdB), eIB);
    end
    if (cmdValid) begin
      logT.push_back(int'(cmdType)); logPA.push_back(int'(cmdPartA));
      logPB.push_back(int'(cmdPartB)); logIA.push_back(int'(cmdIdA));
      logCyc.push_back(cyc);
      served += cmdType[1] ? 2 : 1;
    end
    // drive inputs for the coming edge
    cfgCostRd = 8'(cRd); cfgCostWr = 8'(cWr); cfgBudget = 9'(cBud);
    cfgBacklogLimit = 4'(cLim);
    reqValid = v; reqIsWrite = w; reqPart = 2'(p); reqId = 4'(nextId);
    // model the coming edge
    readyPre = (mW.size() < DEPTH);
    issue = (mBusy == 0) && (mW.size() > 0);
    eValid = issue;
    pair = 0;
    if (issue) begin
      j = -1; starve = 0;
      seen = '{default: 0};
      for (int q = 1; q < mW.size(); q++) begin
        cost = (mW[0] ? cWr : cRd) + (mW[q] ? cWr : cRd);
        if (mP[q] != mP[0] && !(mW[0] && mW[q]) && !seen[mP[q]] && cost <= cBud) begin
          j = q;
          break;
        end
        seen[mP[q]] = 1;
        if (mC[q] >= cLim) starve = 1;
      end
      pair = (j > 0) && !starve;
      ePA = mP[0]; eIA = mI[0];
      if (pair) begin
        eType = (mW[0] || mW[j]) ? 2 : 3;
        ePB = mP[j]; eIB = mI[j];
        for (int q = 1; q < j; q++) if (mC[q] < 15) mC[q]++;
        mW.delete(j); mP.delete(j); mI.delete(j); mC.delete(j);
      end else begin
        eType = mW[0] ? 1 : 0;
        ePB = 0; eIB = 0;
      end
      mW.delete(0); mP.delete(0); mI.delete(0); mC.delete(0);
      lat = (eType == 0) ? 19 : (eType == 1) ? 47 : (eType == 2) ? 48 : 30;
      mBusy = lat - 1;
    end else if (mBusy > 0) begin
      mBusy--;
    end
    if (v && readyPre) begin
      mW.push_back(int'(w)); mP.push_back(p); mI.push_back(nextId % 16); mC.push_back(0);
    end
    if (v) nextId++;
    eReady = (mW.size() < DEPTH);
  endtask

  task automatic push(bit w, int p);
    step(1, w, p);
  endtask

  task automatic drain();
    for (int n = 0; n < 2000; n++) begin
      if (mW.size() == 0 && mBusy == 0) break;
      step(0, 0, 0);
    end
    step(0, 0, 0);
    step(0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(reqReady === 1'b1, "R11 reqReady", int'(reqReady), 1);
    chk(cmdValid === 1'b0 && cmdType == 2'd0, "R11 cmdValid", int'(cmdValid), 0);
    chk(bankBusy === 1'b0, "R11 bankBusy", int'(bankBusy), 0);

    // S1: write then read+write pair, then a read (R4, R9)
    b = logT.size();
    push(1, 0); push(0, 1); push(1, 2); push(0, 3); drain();
    chk(logT[b] == 1, "R10 blocker write", logT[b], 1);
    chk(logT[b+1] == 2, "R4 read-with-write", logT[b+1], 2);
    chk(logCyc[b+1] - logCyc[b] == 47, "R9 write span", logCyc[b+1] - logCyc[b], 47);
    chk(logCyc[b+2] - logCyc[b+1] == 48, "R9 rww span", logCyc[b+2] - logCyc[b+1], 48);

    // S2: two reads to different partitions (R3)
    b = logT.size();
    push(1, 0); push(0, 1); push(0, 2); drain();
    chk(logT[b+1] == 3, "R3 read-with-read", logT[b+1], 3);

    // S3: same partition reads stay serial and ordered (R5, R10)
    b = logT.size();
    push(1, 0); push(0, 1); push(0, 1); drain();
    chk(logT[b+1] == 0 && logT[b+2] == 0, "R5 no same-part pair", logT[b+1], 0);
    chk(logPB[b+1] == 0, "R10 single B zero", logPB[b+1], 0);
    chk(logIA[b+1] < logIA[b+2], "R5 R2 order", logIA[b+1], logIA[b+2]);
    chk(logCyc[b+2] - logCyc[b+1] == 19, "R9 read span", logCyc[b+2] - logCyc[b+1], 19);

    // S4: budget skips the write, pairs with the later read (R7)
    cBud = 6;
    b = logT.size();
    push(1, 0); push(0, 1); push(1, 2); push(0, 3); drain();
    chk(logT[b+1] == 3 && logPB[b+1] == 3, "R7 budget skip", logPB[b+1], 3);
    chk(logT[b+2] == 1, "R7 write alone", logT[b+2], 1);
    cBud = 10;

    // S5: two writes never pair (R4)
    b = logT.size();
    push(1, 0); push(1, 1); push(1, 2); drain();
    chk(logT[b+1] == 1 && logT[b+2] == 1, "R4 no write pair", logT[b+1], 1);

    // S6: oldest compatible partner wins (R6)
    b = logT.size();
    push(1, 0); push(0, 1); push(0, 2); push(0, 3); drain();
    chk(logPB[b+1] == 2, "R6 oldest partner", logPB[b+1], 2);
    chk(logCyc[b+2] - logCyc[b+1] == 30, "R9 rwr span", logCyc[b+2] - logCyc[b+1], 30);

    // S7: backlog limit forces single issue (R8)
    cLim = 1;
    b = logT.size();
    push(1, 0); push(0, 1); push(0, 1); push(0, 1); push(0, 2); push(0, 3); drain();
    chk(logT[b+1] == 3, "R8 first pair", logT[b+1], 3);
    chk(logT[b+2] == 0, "R8 starved forces single", logT[b+2], 0);
    cLim = 3;
    b = logT.size();
    push(1, 0); push(0, 1); push(0, 1); push(0, 1); push(0, 2); push(0, 3); drain();
    chk(logT[b+2] == 3, "R8 under limit pairs", logT[b+2], 3);

    // S8: fill the queue, extra request dropped (R1)
    b = served;
    push(1, 0);
    for (int n = 0; n < 8; n++) push(0, 1);
    @(posedge clk); #1;
    chk(reqReady === 1'b0, "R1 full", int'(reqReady), 0);
    push(0, 2);
    drain();
    chk(served - b == 9, "R1 dropped when full", served - b, 9);

    // S9: random traffic against the model
    cLim = 2; cBud = 9;
    for (int n = 0; n < 1500; n++) step(($urandom % 3) == 0, $urandom % 2, $urandom % 4);
    drain();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule